// File: doc/BRIEF.md
# Soft-Start and Shutdown Sequencer

This block sits beside a PWM generator and decides two things for it on every clock: how far the duty cycle may open, and whether the output drivers may switch at all. It produces a clamp word, `ramp_o`, that climbs slowly from zero to full scale after power-good. The PWM generator uses it as a duty ceiling, so the converter turns on gently. It also produces an enable, `out_en_o`, that drops in the same cycle that a fault or stop request appears.

A supply-low lockout flag forces everything off and zeroes the clamp. A stop request removes output drive at once. The clamp then falls at twice its climbing rate, which recycles the slow start. When the condition goes away, the clamp climbs again from the level it had reached; it does not restart from zero. The climb and fall happen in steps of a programmable size, one step per prescaler tick. A separate output, `kill_o`, tells the PWM latch to end the current pulse. It asserts only once the clamp has reached zero while a stop or lockout is pending.

Top module: `softstart_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), state_o is 0 (idle), ramp_o is 0, out_en_o is 0 and kill_o follows only the inputs.
- R2: The ramp changes only on prescaler ticks, once every PRESCALE clocks counted from reset. On a tick with no lockout and no stop, it rises by step_i.
- R3: The rising ramp saturates at 2^RAMP_W-1. state_o is 3 (run) exactly when the ramp is at full scale and the block is rising; otherwise, while rising, state_o is 2 (ramping).
- R4: While uvlo_i is high, the ramp becomes 0 and state_o becomes 0 at the next edge, whatever shdn_i does. out_en_o is 0 in the same cycle.
- R5: out_en_o is 1 only when both uvlo_i and shdn_i are low and the registered state is 2 or 3. It falls in the same cycle that shdn_i rises.
- R6: While shdn_i is high and uvlo_i is low, each tick lowers the ramp by 2*step_i, saturating at 0. state_o is 1 (discharging) while the ramp is above 0 and 0 once it reaches 0.
- R7: When shdn_i is released, the ramp continues upward from its current value and state_o becomes 2 at the next edge.
- R8: kill_o is 1 exactly when uvlo_i or shdn_i is high and the registered ramp is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_i | input | 1 | Supply-low lockout flag, synchronous |
| shdn_i | input | 1 | Stop request, synchronous |
| step_i | input | STEP_W | Ramp increment per tick |
| ramp_o | output | RAMP_W | Soft-start clamp word for the PWM generator |
| out_en_o | output | 1 | Output-drive enable |
| kill_o | output | 1 | Request to terminate the current PWM pulse |
| state_o | output | 2 | 0 idle, 1 discharging, 2 ramping, 3 run |

## Verification
Embedded properties watch the ramp on every cycle. They check that it moves only on ticks, never rises during a stop, never falls while released, and is cleared after lockout. They also check that the run state coincides with full scale. The bench's scenarios are needed for everything that depends on history or sequence. That covers restart from a partial level, saturation at both ends with large and zero steps, and lockout overriding a stop in progress. It also covers the exact cycle of each step and of the kill request, which the bench compares against its own model on every clock.

// File: rtl/ss_pkg.sv
// Shared types for the soft-start sequencer.
// Assumes the state code is observed externally as a 2-bit value.
package ss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DISCH = 2'd1,
        ST_RAMP  = 2'd2,
        ST_RUN   = 2'd3
    } ss_state_t;
endpackage

// File: rtl/ss_prescaler.sv
// Tick generator: pulses tick_o once every PRESCALE clocks, counted from reset.
// Assumes PRESCALE >= 1; a value of 1 ticks on every clock.
module ss_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    // Combinational tick at the last count.
    assign tick_o = (cnt_q == LAST);

    // Free-running modulo-PRESCALE counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ss_ramp.sv
// Ramp datapath: holds the clamp word, climbing by step on ticks when released,
// falling by twice the step on ticks during a stop, cleared under lockout.
// Assumes STEP_W <= RAMP_W; saturates at both ends.
module ss_ramp #(
    parameter int RAMP_W = 10,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              uvlo_i,
    input  logic              shdn_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [RAMP_W-1:0] ramp_q_o,
    output logic [RAMP_W-1:0] ramp_nxt_o
);
    localparam int EW = RAMP_W + 2;
    localparam logic [EW-1:0] FULL = EW'((1 << RAMP_W) - 1);

    logic [EW-1:0] up_sum;
    logic [EW-1:0] dn_amt;
    logic [EW-1:0] cur_ext;

    // Widened operands for saturating arithmetic.
    always_comb begin
        cur_ext = EW'(ramp_q_o);
        up_sum  = cur_ext + EW'(step_i);
        dn_amt  = EW'(step_i) << 1;
    end

    // Next-value selection with priority lockout > stop > climb.
    always_comb begin
        ramp_nxt_o = ramp_q_o;
        if (uvlo_i) begin
            ramp_nxt_o = '0;
        end else if (shdn_i) begin
            if (tick_i) ramp_nxt_o = (dn_amt >= cur_ext) ? '0 : RAMP_W'(cur_ext - dn_amt);
        end else begin
            if (tick_i) ramp_nxt_o = (up_sum >= FULL) ? RAMP_W'(FULL) : RAMP_W'(up_sum);
        end
    end

    // Ramp register.
    always_ff @(posedge clk) begin
        if (!rst_n) ramp_q_o <= '0;
        else        ramp_q_o <= ramp_nxt_o;
    end

    // R4
    uvlo_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (ramp_q_o == '0));
    // R6
    stop_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo_i && shdn_i) |=> (ramp_q_o <= $past(ramp_q_o)));
    // R7
    release_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo_i && !shdn_i) |=> (ramp_q_o >= $past(ramp_q_o)));
    // R2
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !uvlo_i) |=> $stable(ramp_q_o));
endmodule

// File: rtl/ss_fsm.sv
// Sequencer state and gating: tracks idle/discharging/ramping/run from the
// next ramp value, gates the output enable and raises the pulse-kill request.
// Assumes inputs are already synchronous; no filtering is applied.
module ss_fsm #(
    parameter int RAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo_i,
    input  logic              shdn_i,
    input  logic [RAMP_W-1:0] ramp_q_i,
    input  logic [RAMP_W-1:0] ramp_nxt_i,
    output ss_pkg::ss_state_t state_o,
    output logic              out_en_o,
    output logic              kill_o
);
    import ss_pkg::*;
    localparam logic [RAMP_W-1:0] FULL = '1;

    ss_state_t state_d;

    // Next-state choice from the inputs and the value the ramp will take.
    always_comb begin
        if (uvlo_i)                  state_d = ST_IDLE;
        else if (shdn_i)             state_d = (ramp_nxt_i == '0) ? ST_IDLE : ST_DISCH;
        else if (ramp_nxt_i == FULL) state_d = ST_RUN;
        else                         state_d = ST_RAMP;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= state_d;
    end

    // Immediate output gating and pulse-kill request.
    always_comb begin
        out_en_o = !uvlo_i && !shdn_i && (state_o == ST_RAMP || state_o == ST_RUN);
        kill_o   = (uvlo_i || shdn_i) && (ramp_q_i == '0);
    end

    // R3
    run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN) |-> (ramp_q_i == FULL));
    // R4
    uvlo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (state_o == ST_IDLE));
    // R6
    disch_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DISCH) |-> (ramp_q_i != '0));
endmodule

// File: rtl/softstart_seq.sv
// Soft-start and shutdown sequencer top: prescaler, ramp datapath and
// state/gating logic. Assumes synchronous lockout and stop inputs.
module softstart_seq #(
    parameter int RAMP_W   = 10,
    parameter int STEP_W   = 8,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo_i,
    input  logic              shdn_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              out_en_o,
    output logic              kill_o,
    output logic [1:0]        state_o
);
    logic              tick;
    logic [RAMP_W-1:0] ramp_nxt;
    ss_pkg::ss_state_t st;

    ss_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ss_ramp #(.RAMP_W(RAMP_W), .STEP_W(STEP_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .uvlo_i(uvlo_i),
        .shdn_i(shdn_i), .step_i(step_i), .ramp_q_o(ramp_o), .ramp_nxt_o(ramp_nxt)
    );

    ss_fsm #(.RAMP_W(RAMP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i), .shdn_i(shdn_i),
        .ramp_q_i(ramp_o), .ramp_nxt_i(ramp_nxt), .state_o(st),
        .out_en_o(out_en_o), .kill_o(kill_o)
    );

    // Expose the state code.
    assign state_o = st;
endmodule

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 10;
    localparam int SW = 8;
    localparam int PS = 4;
    localparam int FULL = (1 << RW) - 1;

    logic clk = 0, rst_n = 0, uvlo = 0, shdn = 0;
    logic [SW-1:0] step = 0;
    logic [RW-1:0] ramp;
    logic out_en, kill;
    logic [1:0] state;

    int checks = 0, errors = 0;
    int m_cnt = 0, m_ramp = 0, m_state = 0;
    bit done = 0;

    softstart_seq #(.RAMP_W(RW), .STEP_W(SW), .PRESCALE(PS)) uut (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .shdn_i(shdn), .step_i(step),
        .ramp_o(ramp), .out_en_o(out_en), .kill_o(kill), .state_o(state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ramp = 0; m_state = 0;
        end else begin
            bit tk;
            tk = (m_cnt == PS - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            if (uvlo) begin
                m_ramp = 0; m_state = 0;
            end else if (shdn) begin
                if (tk) m_ramp = (m_ramp - 2 * int'(step) < 0) ? 0 : m_ramp - 2 * int'(step);
                m_state = (m_ramp == 0) ? 0 : 1;
            end else begin
                if (tk) m_ramp = (m_ramp + int'(step) > FULL) ? FULL : m_ramp + int'(step);
                m_state = (m_ramp == FULL) ? 3 : 2;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R2 ramp", int'(ramp), m_ramp);
            chk("R3 state", int'(state), m_state);
            chk("R5 out_en", int'(out_en), int'(!uvlo && !shdn && m_state >= 2));
            chk("R8 kill", int'(kill), int'((uvlo || shdn) && m_ramp == 0));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                cyc(3);
                #2;
                // R1 reset state
                chk("R1 ramp", int'(ramp), 0);
                chk("R1 state", int'(state), 0);
                chk("R1 out_en", int'(out_en), 0);
                rst_n = 1; step = 100;
                cyc(60);
                #2;
                chk("R3 full", int'(ramp), FULL);
                chk("R3 run", int'(state), 3);
                shdn = 1;
                #1;
                chk("R5 immediate off", int'(out_en), 0);
                cyc(9);
                #2;
                chk("R6 discharging", int'(state), 1);
                shdn = 0;
                cyc(1);
                #2;
                // R7 restart from partial level
                chk("R7 ramping", int'(state), 2);
                chk("R7 not zero", int'(ramp > 0), 1);
                cyc(40);
                shdn = 1;
                cyc(30);
                #2;
                chk("R6 zero idle", int'(state), 0);
                chk("R8 kill at zero", int'(kill), 1);
                shdn = 0; step = 255;
                cyc(10);
                shdn = 1; uvlo = 1;
                cyc(1);
                #2;
                chk("R4 ramp cleared", int'(ramp), 0);
                chk("R4 idle", int'(state), 0);
                uvlo = 0; shdn = 0; step = 0;
                cyc(20);
                #2;
                chk("R2 zero step holds", int'(ramp), 0);
                step = 7;
                cyc(30);
                rst_n = 0;
                cyc(2);
                #2;
                chk("R1 re-reset", int'(ramp), 0);
                done = 1;
            end
            begin
                cyc(5000);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule